// File: doc/BRIEF.md
# VGA Timing and Bar-Pattern Generator

This block produces 640x480 at 60 Hz raster timing from a clock running at the pixel rate. A horizontal position counter advances on every clock and a vertical position counter advances once per line. From these two counters the block decodes negative-polarity horizontal and vertical sync pulses and a display-enable flag. It also reports the current raster coordinate.

Inside the visible area the block paints a synthetic test image taken from the counters. Red vertical stripes repeat every 16 pixels, eight on and eight off. Blue horizontal bands repeat every 32 lines. A one-pixel white frame runs along the outer edge of the visible area and takes priority over the stripes and bands. Outside the visible area every colour channel is zero.

All outputs are registered and change on the same clock edge. The sync, enable, coordinate and colour outputs therefore always describe the same raster position. Every porch, sync and visible length is a parameter, so the generator can also be built for other modes.

Top module: `vga_bar_timing_gen`

## Requirements
- R1: `pix_x` counts 0, 1, ... up to H_TOTAL-1 (800 by default: 640 visible, 16 front porch, 96 sync, 48 back porch) and returns to 0 on the clock after H_TOTAL-1.
- R2: `pix_y` holds its value during a line. It increases by one on the clock where `pix_x` returns to 0, and it returns to 0 after V_TOTAL-1 (525 by default: 480 visible, 10 front porch, 2 sync, 33 back porch).
- R3: `hsync_n` is 0 exactly while `pix_x` is in [H_ACTIVE+H_FRONT, H_ACTIVE+H_FRONT+H_SYNC) and is 1 at every other position.
- R4: `vsync_n` is 0 exactly while `pix_y` is in [V_ACTIVE+V_FRONT, V_ACTIVE+V_FRONT+V_SYNC) and is 1 on every other line.
- R5: `de` is 1 exactly when `pix_x` < H_ACTIVE and `pix_y` < V_ACTIVE. When `de` is 0, `red`, `green` and `blue` are all 0.
- R6: At a visible, non-border position, `red` is all ones when bit 3 of `pix_x` is 1 and is 0 otherwise.
- R7: At a visible, non-border position, `blue` is all ones when bit 4 of `pix_y` is 1 and is 0 otherwise, and `green` is 0.
- R8: At visible positions with `pix_x` equal to 0 or H_ACTIVE-1, or `pix_y` equal to 0 or V_ACTIVE-1, all three channels are all ones. This overrides R6 and R7.
- R9: While `rst` is sampled high, the outputs are `pix_x`=0, `pix_y`=0, `hsync_n`=1, `vsync_n`=1, `de`=0 and all colours 0. The first clock after `rst` falls presents position (0,0), and the next clock presents (1,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable, high in the visible area |
| pix_x | output | XW | Horizontal position of the current outputs |
| pix_y | output | YW | Vertical position of the current outputs |
| red | output | COLOR_W | Red channel |
| green | output | COLOR_W | Green channel |
| blue | output | COLOR_W | Blue channel |

## Verification
The bench builds the generator with a reduced raster. The visible area is 32x40 and the line is 47 clocks (front porch 4, sync 6, back porch 5). The frame is 47 lines (front porch 2, sync 2, back porch 3). The stripe bit stays at 3 and the band bit at 4. With these values a whole frame lasts about 2,200 clocks, so both counter wraps, both sync windows, all four border edges, several stripe and band transitions, and two complete frames can be compared position by position within the run.

// File: rtl/vga_bar_pkg.sv
package vga_bar_pkg;

  // true when pos lies in [lo, lo+len)
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned lo,
                                   input int unsigned len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  // single-bit select of a coordinate
  function automatic logic coord_bit(input int unsigned value,
                                     input int unsigned idx);
    return ((value >> idx) & 1) == 1;
  endfunction

  // outer one-pixel frame of the visible area
  function automatic logic on_edge(input int unsigned x,
                                   input int unsigned y,
                                   input int unsigned w,
                                   input int unsigned h);
    return (x == 0) || (y == 0) || (x == w - 1) || (y == h - 1);
  endfunction

endpackage

// File: rtl/vga_axis_counter.sv
module vga_axis_counter #(
  parameter int TOTAL = 800,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  assign wrap = adv && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (wrap) count <= '0;
    else if (adv)  count <= count + 1'b1;
  end
endmodule

// File: rtl/vga_sync_decode.sv
module vga_sync_decode #(
  parameter int ACTIVE = 640,
  parameter int FRONT  = 16,
  parameter int SYNC   = 96,
  parameter int W      = 10
) (
  input  logic [W-1:0] pos,
  output logic         visible,
  output logic         sync_n
);
  import vga_bar_pkg::*;
  localparam int SYNC_START = ACTIVE + FRONT;

  always_comb begin
    visible = (32'(pos) < ACTIVE);
    sync_n  = !in_span(32'(pos), SYNC_START, SYNC);
  end
endmodule

// File: rtl/vga_bar_painter.sv
module vga_bar_painter #(
  parameter int H_ACTIVE   = 640,
  parameter int V_ACTIVE   = 480,
  parameter int XW         = 10,
  parameter int YW         = 10,
  parameter int COLOR_W    = 8,
  parameter int STRIPE_BIT = 3,
  parameter int BAND_BIT   = 4
) (
  input  logic [XW-1:0]      x,
  input  logic [YW-1:0]      y,
  input  logic               visible,
  output logic [COLOR_W-1:0] r,
  output logic [COLOR_W-1:0] g,
  output logic [COLOR_W-1:0] b
);
  import vga_bar_pkg::*;
  localparam logic [COLOR_W-1:0] FULL = '1;

  logic edge_px, stripe_on, band_on;

  always_comb begin
    edge_px   = on_edge(32'(x), 32'(y), H_ACTIVE, V_ACTIVE);
    stripe_on = coord_bit(32'(x), STRIPE_BIT);
    band_on   = coord_bit(32'(y), BAND_BIT);
    r = '0;
    g = '0;
    b = '0;
    if (visible) begin
      if (edge_px) begin
        r = FULL;
        g = FULL;
        b = FULL;
      end else begin
        r = stripe_on ? FULL : '0;
        b = band_on   ? FULL : '0;
      end
    end
  end
endmodule

// File: rtl/vga_bar_timing_gen.sv
module vga_bar_timing_gen #(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FRONT    = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 33,
  parameter int COLOR_W    = 8,
  parameter int STRIPE_BIT = 3,
  parameter int BAND_BIT   = 4,
  localparam int H_TOTAL   = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL   = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int XW        = $clog2(H_TOTAL),
  localparam int YW        = $clog2(V_TOTAL)
) (
  input  logic               clk,
  input  logic               rst,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               de,
  output logic [XW-1:0]      pix_x,
  output logic [YW-1:0]      pix_y,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue
);
  // raster position and its events
  logic [XW-1:0] h_cnt;
  logic [YW-1:0] v_cnt;
  logic          line_end;
  logic          frame_end;

  vga_axis_counter #(.TOTAL(H_TOTAL), .W(XW)) u_hcnt (
    .clk(clk), .rst(rst), .adv(1'b1), .count(h_cnt), .wrap(line_end)
  );

  vga_axis_counter #(.TOTAL(V_TOTAL), .W(YW)) u_vcnt (
    .clk(clk), .rst(rst), .adv(line_end), .count(v_cnt), .wrap(frame_end)
  );

  // per-axis window decode
  logic h_vis, v_vis, h_sync_n, v_sync_n, vis_area;

  vga_sync_decode #(.ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .W(XW)) u_hdec (
    .pos(h_cnt), .visible(h_vis), .sync_n(h_sync_n)
  );

  vga_sync_decode #(.ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .W(YW)) u_vdec (
    .pos(v_cnt), .visible(v_vis), .sync_n(v_sync_n)
  );

  assign vis_area = h_vis && v_vis;

  // image
  logic [COLOR_W-1:0] r_nxt, g_nxt, b_nxt;

  vga_bar_painter #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .XW(XW), .YW(YW),
    .COLOR_W(COLOR_W), .STRIPE_BIT(STRIPE_BIT), .BAND_BIT(BAND_BIT)
  ) u_paint (
    .x(h_cnt), .y(v_cnt), .visible(vis_area), .r(r_nxt), .g(g_nxt), .b(b_nxt)
  );

  // one output stage so every output moves on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      de      <= 1'b0;
      pix_x   <= '0;
      pix_y   <= '0;
      red     <= '0;
      green   <= '0;
      blue    <= '0;
    end else begin
      hsync_n <= h_sync_n;
      vsync_n <= v_sync_n;
      de      <= vis_area;
      pix_x   <= h_cnt;
      pix_y   <= v_cnt;
      red     <= r_nxt;
      green   <= g_nxt;
      blue    <= b_nxt;
    end
  end
endmodule

// File: rtl/vga_bar_timing_chk.sv
module vga_bar_timing_chk #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int COLOR_W  = 8,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int XW      = $clog2(H_TOTAL),
  localparam int YW      = $clog2(V_TOTAL)
) (
  input logic               clk,
  input logic               rst,
  input logic               hsync_n,
  input logic               vsync_n,
  input logic               de,
  input logic [XW-1:0]      pix_x,
  input logic [YW-1:0]      pix_y,
  input logic [COLOR_W-1:0] red,
  input logic [COLOR_W-1:0] green,
  input logic [COLOR_W-1:0] blue
);
  localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);
  localparam int HS_LO = H_ACTIVE + H_FRONT;
  localparam int HS_HI = HS_LO + H_SYNC;
  localparam int VS_LO = V_ACTIVE + V_FRONT;
  localparam int VS_HI = VS_LO + V_SYNC;
  localparam logic [COLOR_W-1:0] FULL = '1;

  // the first output after reset repeats position 0
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  logic x_edge, y_edge;
  assign x_edge = (pix_x == '0) || (32'(pix_x) == H_ACTIVE - 1);
  assign y_edge = (pix_y == '0) || (32'(pix_y) == V_ACTIVE - 1);

  AST_X_WRAP: assert property (@(posedge clk) disable iff (rst)
    primed && pix_x == X_LAST |=> pix_x == '0); // R1
  AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
    primed && pix_x != X_LAST |=> pix_x == $past(pix_x) + 1'b1); // R1
  AST_Y_STEADY: assert property (@(posedge clk) disable iff (rst)
    primed && pix_x != X_LAST |=> $stable(pix_y)); // R2
  AST_Y_STEP: assert property (@(posedge clk) disable iff (rst)
    primed && pix_x == X_LAST && pix_y != Y_LAST |=> pix_y == $past(pix_y) + 1'b1); // R2
  AST_Y_WRAP: assert property (@(posedge clk) disable iff (rst)
    primed && pix_x == X_LAST && pix_y == Y_LAST |=> pix_y == '0); // R2
  AST_HSYNC_IN: assert property (@(posedge clk) disable iff (rst)
    32'(pix_x) >= HS_LO && 32'(pix_x) < HS_HI |-> !hsync_n); // R3
  AST_HSYNC_OUT: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> 32'(pix_x) >= HS_LO && 32'(pix_x) < HS_HI); // R3
  AST_VSYNC_IN: assert property (@(posedge clk) disable iff (rst)
    32'(pix_y) >= VS_LO && 32'(pix_y) < VS_HI |-> !vsync_n); // R4
  AST_VSYNC_OUT: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> 32'(pix_y) >= VS_LO && 32'(pix_y) < VS_HI); // R4
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
    !de |-> red == '0 && green == '0 && blue == '0); // R5
  AST_DE_REGION: assert property (@(posedge clk) disable iff (rst)
    de |-> 32'(pix_x) < H_ACTIVE && 32'(pix_y) < V_ACTIVE); // R5
  AST_GREEN_WHITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    green != '0 |-> red == FULL && blue == FULL); // R7
  AST_BORDER_WHITE: assert property (@(posedge clk) disable iff (rst)
    de && (x_edge || y_edge) |-> red == FULL && green == FULL && blue == FULL); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> hsync_n && vsync_n && !de && pix_x == '0 && pix_y == '0); // R9
endmodule

bind vga_bar_timing_gen vga_bar_timing_chk #(
  .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
  .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
  .COLOR_W(COLOR_W)
) u_chk (.*);

// File: tb/vga_bar_timing_gen_bench.sv
module vga_bar_timing_gen_bench;
  localparam int HA = 32, HF = 4, HS = 6, HB = 5;
  localparam int VA = 40, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_n, vsync_n, de;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;
  logic [CW-1:0] red, green, blue;

  always #5 clk = ~clk;

  vga_bar_timing_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .COLOR_W(CW), .STRIPE_BIT(3), .BAND_BIT(4)
  ) u_vga_bar_timing_gen (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .red(red), .green(green), .blue(blue)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      if (failures <= 30)
        $display("FAIL %s actual=%0d expected=%0d at x=%0d y=%0d t=%0t",
                 req, act, exp, pix_x, pix_y, $time);
    end
  endtask

  // expected outputs at raster position (h,v), written as arithmetic
  function automatic int exp_hs(input int h);
    return (h < HA + HF || h >= HA + HF + HS) ? 1 : 0;
  endfunction
  function automatic int exp_vs(input int v);
    return (v < VA + VF || v >= VA + VF + VS) ? 1 : 0;
  endfunction
  function automatic int exp_de(input int h, input int v);
    return (h < HA && v < VA) ? 1 : 0;
  endfunction
  function automatic int rim(input int h, input int v);
    return (h == 0 || v == 0 || h == HA - 1 || v == VA - 1) ? 1 : 0;
  endfunction
  function automatic int exp_r(input int h, input int v);
    if (exp_de(h, v) == 0) return 0;
    if (rim(h, v) == 1) return 255;
    return ((h / 8) % 2 == 1) ? 255 : 0;
  endfunction
  function automatic int exp_g(input int h, input int v);
    return (exp_de(h, v) == 1 && rim(h, v) == 1) ? 255 : 0;
  endfunction
  function automatic int exp_b(input int h, input int v);
    if (exp_de(h, v) == 0) return 0;
    if (rim(h, v) == 1) return 255;
    return ((v / 16) % 2 == 1) ? 255 : 0;
  endfunction

  // vector table: {x, y, flags} ; flags = {r_full, g_full, b_full, de, hsync_n, vsync_n}
  localparam int NV = 15;
  localparam logic [17:0] TBL [NV] = '{
    {6'd0,  6'd0,  6'b111111},  // R8 corner
    {6'd5,  6'd1,  6'b000111},  // R6 R7 both off
    {6'd9,  6'd2,  6'b100111},  // R6 stripe on
    {6'd31, 6'd5,  6'b111111},  // R8 right edge
    {6'd32, 6'd5,  6'b000011},  // R5 first blank pixel
    {6'd36, 6'd5,  6'b000001},  // R3 sync start
    {6'd41, 6'd5,  6'b000001},  // R3 sync last
    {6'd42, 6'd5,  6'b000011},  // R3 sync ended
    {6'd9,  6'd17, 6'b101111},  // R6 R7 both on
    {6'd20, 6'd18, 6'b001111},  // R7 band only
    {6'd12, 6'd39, 6'b111111},  // R8 bottom edge
    {6'd10, 6'd40, 6'b000011},  // R5 blank line
    {6'd10, 6'd42, 6'b000010},  // R4 vsync start
    {6'd46, 6'd43, 6'b000010},  // R4 vsync last, line end
    {6'd46, 6'd46, 6'b000011}   // R2 last position
  };

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int ph, pv;
    // R9 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hsync_n == 1'b1 && vsync_n == 1'b1, "R9 sync idle in reset", {hsync_n, vsync_n}, 3);
    chk(de == 1'b0, "R9 de low in reset", de, 0);
    chk(pix_x == '0 && pix_y == '0, "R9 position zero in reset", pix_x + pix_y, 0);
    chk(red == '0 && green == '0 && blue == '0, "R9 colour zero in reset", red | green | blue, 0);
    rst = 1'b0;

    // full sweep of two frames against the model
    ph = 0;
    pv = 0;
    for (int n = 0; n < 2 * HT * VT; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk(int'(pix_x) == ph, "R1 x position", pix_x, ph);
      chk(int'(pix_y) == pv, "R2 y position", pix_y, pv);
      chk(int'(hsync_n) == exp_hs(ph), "R3 hsync", hsync_n, exp_hs(ph));
      chk(int'(vsync_n) == exp_vs(pv), "R4 vsync", vsync_n, exp_vs(pv));
      chk(int'(de) == exp_de(ph, pv), "R5 display enable", de, exp_de(ph, pv));
      chk(int'(red) == exp_r(ph, pv), "R6 R8 red", red, exp_r(ph, pv));
      chk(int'(green) == exp_g(ph, pv), "R7 R8 green", green, exp_g(ph, pv));
      chk(int'(blue) == exp_b(ph, pv), "R7 R8 blue", blue, exp_b(ph, pv));
      if (ph == HT - 1) begin
        ph = 0;
        pv = (pv == VT - 1) ? 0 : pv + 1;
      end else begin
        ph = ph + 1;
      end
    end

    // table of vectors, walked in raster order through one frame
    do_reset();
    for (int i = 0; i < NV; i++) begin
      int guard;
      logic [5:0] fl;
      guard = 0;
      fl = TBL[i][5:0];
      do begin
        @(negedge clk);
        guard++;
      end while (!(int'(pix_x) == int'(TBL[i][17:12]) && int'(pix_y) == int'(TBL[i][11:6]))
                 && guard < 3 * HT * VT);
      chk(guard < 3 * HT * VT, "R1 R2 vector position reached", pix_x, TBL[i][17:12]);
      chk(red == (fl[5] ? 8'hFF : 8'h00), "R6 R8 vector red", red, fl[5] ? 255 : 0);
      chk(green == (fl[4] ? 8'hFF : 8'h00), "R7 R8 vector green", green, fl[4] ? 255 : 0);
      chk(blue == (fl[3] ? 8'hFF : 8'h00), "R7 R8 vector blue", blue, fl[3] ? 255 : 0);
      chk(de == fl[2], "R5 vector de", de, fl[2]);
      chk(hsync_n == fl[1], "R3 vector hsync", hsync_n, fl[1]);
      chk(vsync_n == fl[0], "R4 vector vsync", vsync_n, fl[0]);
    end

    // R9 reset in mid-frame, then restart at (0,0)
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pix_x == '0 && pix_y == '0 && de == 1'b0, "R9 mid-frame reset clears", pix_x + pix_y, 0);
    chk(red == '0 && hsync_n == 1'b1 && vsync_n == 1'b1, "R9 mid-frame reset idle", red, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(pix_x == '0 && pix_y == '0 && de == 1'b1, "R9 first edge shows origin", pix_x, 0);
    chk(red == 8'hFF && green == 8'hFF && blue == 8'hFF, "R9 R8 origin is white", green, 255);
    @(posedge clk);
    @(negedge clk);
    chk(int'(pix_x) == 1 && pix_y == '0, "R9 second edge shows x=1", pix_x, 1);

    // R1 R2 wrap of line and frame from the top of a fresh frame
    while (!(int'(pix_x) == HT - 1 && int'(pix_y) == VT - 1)) @(negedge clk);
    @(negedge clk);
    chk(pix_x == '0 && pix_y == '0, "R1 R2 frame wrap to origin", pix_x + pix_y, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule